// File: doc/BRIEF.md
# EDO DRAM Device Emulator

This block stands in for a small x16 extended-data-out DRAM so that a memory controller can be verified against it in synthesizable logic. All strobes (row strobe, lower and upper column strobes, write enable, output enable) and the multiplexed address are sampled on a fast system clock. Each operation is decoded from the order in which the strobes fall. Every strobe is active low. Storage is a reduced register array of 2^(2*ADDR_W) words, addressed by the latched row followed by the column.

The model latches a row when the row strobe falls with both column strobes high. It then treats every later column-strobe fall as a page access: a read when write enable is high and output enable is low, or a write when write enable is low. A read drives one byte lane for each column strobe that is low, and it keeps driving after the column strobes rise, which is the extended-output behaviour. A row-strobe fall while a column strobe is already low is a refresh. It is either a column-before-row refresh or a hidden refresh that follows a read. Either kind advances a refresh counter and opens no row. A column strobe that falls while the row strobe is low but no row is open sets a sticky violation flag.

The data bus is split into `dqIn`, `dqOut` and a per-lane drive enable `dqOe`. A lane whose enable is 0 is high-impedance. Every action takes effect on the clock edge that first samples the strobe change, and it is visible at the ports after that edge.

Top module: `edoDramModel`

## Requirements
- R1: While `rstN` is low and after it is released, `dqOe` is 00, `refreshCount` is 0 and `protoErr` is 0.
- R2: A column-strobe fall with a row open and `weN` low stores `dqIn` at word {row, column}. During the write, `dqOe` stays 00.
- R3: A write updates only the byte lanes whose column strobe is low: `lcasN` selects bits 7:0 and `ucasN` selects bits 15:8. The other lane keeps its stored byte.
- R4: A column-strobe fall with a row open, `weN` high and `oeN` low drives the stored word on `dqOut`. `dqOe` = {~ucasN, ~lcasN} as sampled at that fall.
- R5: After a read, when the column strobes rise while `rasN` and `oeN` stay low and `weN` stays high, `dqOe` and `dqOut` keep their values.
- R6: `dqOe` returns to 00 one edge after `oeN` is high, after `weN` is low, or after `rasN`, `lcasN` and `ucasN` are all high.
- R7: A column strobe falling while `rasN` is high, followed by `rasN` falling, increments `refreshCount` by one. During this sequence the address and `weN` are ignored, no word is written and `dqOe` stays 00.
- R8: After a read, raising `rasN` and lowering it again while a column strobe stays low increments `refreshCount` by one. `dqOe` and `dqOut` hold the read data throughout.
- R9: A column-strobe fall while `rasN` is low and no row is open sets `protoErr`, which stays set until reset. No write takes place.
- R10: Successive column-strobe falls within one row cycle access different columns of the same latched row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| lcasN | input | 1 | Column strobe for bits 7:0, active low |
| ucasN | input | 1 | Column strobe for bits 15:8, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dqIn | input | 16 | Write data from the controller |
| dqOut | output | 16 | Read data toward the controller |
| dqOe | output | 2 | Per-lane drive enable (bit 0 = low byte) |
| protoErr | output | 1 | Sticky protocol-violation flag |
| refreshCount | output | CNT_W | Count of refresh cycles, wraps |

## Verification
A wrong open-row state shows on the first column-strobe fall of the next cycle. Either a read returns another row's word, or `protoErr` rises where it should not, so the fault appears one edge after the stimulus. A stale drive state shows as `dqOe` staying set one edge after output enable rises, write enable falls or all strobes go idle. A bad edge detector shows as a refresh counted on an ordinary row open, or as a refresh that is missed, and the count is compared right after each row-strobe fall. A write that hits the wrong lane stays hidden until that word is read back, so every random write is later compared through word reads.

// File: rtl/edoPkg.sv
package edoPkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic             latchRow;
    logic             doWrite;
    logic             doRead;
    logic [LANES-1:0] lanes;
    logic             dropOut;
  } edoCmdT;
endpackage

// File: rtl/edoCtrl.sv
module edoCtrl
  import edoPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic             lcasN,
  input  logic             ucasN,
  input  logic             weN,
  input  logic             oeN,
  output edoCmdT           cmd,
  output logic             protoErr,
  output logic [CNT_W-1:0] refreshCount
);
  logic rasQ, lcasQ, ucasQ, rowOpen;
  logic rasFall, casFall, anyCasLow, access, refreshHit, badCol;

  // Edge detection against the previous sample.
  always_comb begin
    rasFall    = rasQ & ~rasN;
    casFall    = (lcasQ & ~lcasN) | (ucasQ & ~ucasN);
    anyCasLow  = ~lcasN | ~ucasN;
    access     = casFall & ~rasN & rowOpen;
    refreshHit = rasFall & anyCasLow;
    badCol     = casFall & ~rasN & ~rowOpen;
    cmd.latchRow = rasFall & ~anyCasLow;
    cmd.doWrite  = access & ~weN;
    cmd.doRead   = access & weN & ~oeN;
    cmd.lanes    = {~ucasN, ~lcasN};
    cmd.dropOut  = oeN | ~weN | (rasN & lcasN & ucasN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasQ         <= 1'b1;
      lcasQ        <= 1'b1;
      ucasQ        <= 1'b1;
      rowOpen      <= 1'b0;
      protoErr     <= 1'b0;
      refreshCount <= '0;
    end else begin
      rasQ  <= rasN;
      lcasQ <= lcasN;
      ucasQ <= ucasN;
      if (cmd.latchRow)  rowOpen <= 1'b1;
      else if (rasN)     rowOpen <= 1'b0;
      if (badCol)        protoErr <= 1'b1;
      if (refreshHit)    refreshCount <= refreshCount + 1'b1;
    end
  end
endmodule

// File: rtl/edoDatapath.sv
module edoDatapath
  import edoPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dqIn,
  input  edoCmdT                  cmd,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic [LANES-1:0]        dqOe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << (2 * ADDR_W);

  logic [DATA_W-1:0]   mem [DEPTH];
  logic [ADDR_W-1:0]   rowQ;
  logic [2*ADDR_W-1:0] idx;

  assign idx = {rowQ, addr};

  // Array and row latch carry no reset.
  always_ff @(posedge clk) begin
    if (cmd.latchRow) rowQ <= addr;
    for (int b = 0; b < LANES; b++) begin
      if (cmd.doWrite && cmd.lanes[b])
        mem[idx][b*LANE_W +: LANE_W] <= dqIn[b*LANE_W +: LANE_W];
    end
    if (cmd.doRead) dqOut <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dqOe <= '0;
    else if (cmd.dropOut) dqOe <= '0;
    else if (cmd.doRead)  dqOe <= cmd.lanes;
  end
endmodule

// File: rtl/edoDramModel.sv
module edoDramModel
  import edoPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rasN,
  input  logic                    lcasN,
  input  logic                    ucasN,
  input  logic                    weN,
  input  logic                    oeN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dqIn,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic [LANES-1:0]        dqOe,
  output logic                    protoErr,
  output logic [CNT_W-1:0]        refreshCount
);
  edoCmdT cmd;

  edoCtrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .cmd(cmd), .protoErr(protoErr),
    .refreshCount(refreshCount)
  );

  edoDatapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .addr(addr), .dqIn(dqIn), .cmd(cmd),
    .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: rtl/edoDramChecker.sv
module edoDramChecker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rasN,
  input logic             lcasN,
  input logic             ucasN,
  input logic             weN,
  input logic             oeN,
  input logic [1:0]       dqOe,
  input logic             protoErr,
  input logic [CNT_W-1:0] refreshCount
);
  // R6: output enable high releases the bus on the next edge
  a_r6_oe_release: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> (dqOe == 2'b00));

  // R6: all strobes idle releases the bus
  a_r6_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && lcasN && ucasN) |=> (dqOe == 2'b00));

  // R4: a lane only starts driving after its own column strobe was low
  a_r4_upper_lane: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe[1]) |-> !$past(ucasN));
  a_r4_lower_lane: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe[0]) |-> !$past(lcasN));

  // R2: driving never begins from a write-enabled sample
  a_r2_no_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|dqOe) |-> ($past(weN) && !$past(oeN)));

  // R7/R8: refresh counter steps by one and only on a row-strobe fall
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (refreshCount != $past(refreshCount)) |->
      (refreshCount == CNT_W'($past(refreshCount) + 1'b1)));
  a_r8_count_on_ras_fall: assert property (@(posedge clk) disable iff (!rstN)
    (refreshCount != $past(refreshCount)) |->
      (!$past(rasN) && $past(rasN, 2)));

  // R9: violation flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

bind edoDramModel edoDramChecker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
  .weN(weN), .oeN(oeN), .dqOe(dqOe), .protoErr(protoErr),
  .refreshCount(refreshCount)
);

// File: tb/edoDramModel_tb_top.sv
module edoDramModel_tb_top;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rstN, rasN, lcasN, ucasN, weN, oeN;
  logic [AW-1:0] addr;
  logic [15:0] dqIn, dqOut;
  logic [1:0] dqOe;
  logic protoErr;
  logic [7:0] refreshCount;

  int checks = 0;
  int fails = 0;
  int expRef = 0;
  int curRow = 0;
  logic [15:0] expMem [64];

  always #4 clk = ~clk;

  edoDramModel #(.ADDR_W(AW), .LANE_W(8), .CNT_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .addr(addr), .dqIn(dqIn), .dqOut(dqOut),
    .dqOe(dqOe), .protoErr(protoErr), .refreshCount(refreshCount)
  );

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] laneMask(input logic [1:0] lanes);
    return {{8{lanes[1]}}, {8{lanes[0]}}};
  endfunction

  function automatic logic [15:0] mergeWrite(input logic [15:0] old,
      input logic [15:0] nw, input logic [1:0] lanes);
    return (old & ~laneMask(lanes)) | (nw & laneMask(lanes));
  endfunction

  task automatic idle;
    rasN = 1; lcasN = 1; ucasN = 1; weN = 1; oeN = 1;
  endtask

  task automatic openRow(input int r);
    addr = AW'(r); rasN = 0; curRow = r;
    step;
  endtask

  task automatic closeRow;
    idle;
    step;
    chk(dqOe == 2'b00, "R6 idle release", 32'(dqOe), 0);
  endtask

  task automatic writeCol(input int c, input logic [1:0] lanes,
                          input logic [15:0] data);
    int i = curRow * 8 + c;
    addr = AW'(c); weN = 0; oeN = 1; dqIn = data;
    {ucasN, lcasN} = ~lanes;
    step;
    chk(dqOe == 2'b00, "R2 no drive on write", 32'(dqOe), 0);
    expMem[i] = mergeWrite(expMem[i], data, lanes);
    lcasN = 1; ucasN = 1; weN = 1;
    step;
  endtask

  task automatic readCol(input int c, input logic [1:0] lanes,
                         input string tag);
    int i = curRow * 8 + c;
    logic [15:0] m = laneMask(lanes);
    addr = AW'(c); weN = 1; oeN = 0;
    {ucasN, lcasN} = ~lanes;
    step;
    chk(dqOe == lanes, "R4 lanes", 32'(dqOe), 32'(lanes));
    chk((dqOut & m) == (expMem[i] & m), tag, 32'(dqOut & m), 32'(expMem[i] & m));
    lcasN = 1; ucasN = 1;
    step;
    chk(dqOe == lanes && (dqOut & m) == (expMem[i] & m), "R5 EDO hold",
        32'(dqOut & m), 32'(expMem[i] & m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    idle; rstN = 0; addr = '0; dqIn = '0;
    step;
    chk(dqOe == 2'b00, "R1 dqOe in reset", 32'(dqOe), 0);
    step; step;
    rstN = 1;
    step;
    chk(dqOe == 2'b00, "R1 dqOe", 32'(dqOe), 0);
    chk(refreshCount == 0, "R1 refreshCount", 32'(refreshCount), 0);
    chk(protoErr == 0, "R1 protoErr", 32'(protoErr), 0);

    // R2/R10: fill every word, one page burst per row
    for (int r = 0; r < 8; r++) begin
      openRow(r);
      for (int c = 0; c < 8; c++) writeCol(c, 2'b11, 16'($urandom));
      closeRow;
    end

    // R3: upper-lane-only write, then full-word read
    openRow(2);
    writeCol(5, 2'b10, 16'hA5C3);
    readCol(5, 2'b11, "R3 byte write lanes");
    closeRow;

    // R4/R10: byte reads and page reads in one row
    openRow(4);
    readCol(1, 2'b01, "R4 lower byte read");
    readCol(2, 2'b10, "R4 upper byte read");
    readCol(6, 2'b11, "R10 page read");
    readCol(0, 2'b11, "R10 page read");
    oeN = 1; step;
    chk(dqOe == 2'b00, "R6 oe release", 32'(dqOe), 0);
    closeRow;

    openRow(1);
    readCol(3, 2'b11, "R4 word read");
    weN = 0; step;
    chk(dqOe == 2'b00, "R6 we release", 32'(dqOe), 0);
    closeRow;

    // random page traffic
    for (int n = 0; n < 300; n++) begin
      openRow(int'($urandom_range(0, 7)));
      for (int k = 0; k < int'($urandom_range(1, 4)); k++) begin
        int c = int'($urandom_range(0, 7));
        logic [1:0] ln = 2'($urandom_range(1, 3));
        if ($urandom_range(0, 1) == 1) writeCol(c, ln, 16'($urandom));
        else readCol(c, ln, "R10 random read");
      end
      closeRow;
    end
    chk(refreshCount == 0, "R7 no refresh in plain traffic", 32'(refreshCount), 0);

    // R7: column-before-row refresh with write enable low
    idle; weN = 0; dqIn = 16'hFFFF; addr = 3'd3; lcasN = 0;
    step;
    chk(dqOe == 2'b00, "R7 bus idle", 32'(dqOe), 0);
    rasN = 0; addr = 3'd6;
    step;
    expRef++;
    chk(refreshCount == 8'(expRef), "R7 count", 32'(refreshCount), 32'(expRef));
    chk(dqOe == 2'b00, "R7 bus idle", 32'(dqOe), 0);
    idle; step;
    chk(protoErr == 0, "R7 no violation", 32'(protoErr), 0);
    openRow(0);
    readCol(3, 2'b11, "R7 memory untouched");
    closeRow;
    openRow(6);
    readCol(3, 2'b11, "R7 memory untouched");
    closeRow;

    // R8: hidden refresh after a read
    openRow(5);
    addr = 3'd4; weN = 1; oeN = 0; lcasN = 0; ucasN = 0;
    step;
    chk(dqOe == 2'b11, "R8 read drive", 32'(dqOe), 3);
    rasN = 1; step;
    chk(dqOe == 2'b11, "R8 held while row strobe high", 32'(dqOe), 3);
    rasN = 0; step;
    expRef++;
    chk(refreshCount == 8'(expRef), "R8 count", 32'(refreshCount), 32'(expRef));
    chk(dqOe == 2'b11 && dqOut == expMem[44], "R8 data held",
        32'(dqOut), 32'(expMem[44]));
    closeRow;

    // R9: column strobe with no open row
    idle; lcasN = 0; step;
    rasN = 0; step;
    expRef++;
    lcasN = 1; step;
    chk(protoErr == 0, "R9 flag clear before violation", 32'(protoErr), 0);
    weN = 0; dqIn = 16'h1357; addr = 3'd0; lcasN = 0; ucasN = 0;
    step;
    chk(protoErr == 1, "R9 flag set", 32'(protoErr), 1);
    closeRow;
    step;
    chk(protoErr == 1, "R9 flag sticky", 32'(protoErr), 1);
    openRow(5);
    readCol(0, 2'b11, "R9 no write on violation");
    closeRow;
    chk(refreshCount == 8'(expRef), "R7 final count", 32'(refreshCount), 32'(expRef));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule